// File: doc/BRIEF.md
# Tick Compare Timer Trio

This block holds three free-running 63-bit tick counters, one per timer role: the processor tick, the system tick and the hypervisor system tick. Each counter has its own compare register. A flag in bit 63 of the count marks the counter as not readable by unprivileged code. Bit 63 of the compare register turns the compare off. Each counter advances once per cycle in which its prescaler enable is high, so the 100 MHz nominal tick rate comes from an outside divider rather than from the block clock.

When a counter reaches its compare value while the compare is armed, the block drives a one-cycle set pulse towards an external soft-interrupt register and raises a wake pulse for the processor. The tick channel drives the timer-match bit. The two system-tick channels share the system-match bit.

Software reaches the registers through a plain single-port write strobe with channel and register selects. A combinational read path has its own selects. There is no streaming data path, so every pin is a plain control or status signal with no valid/ready handshake. The privilege checks that use the NPT flag sit outside this block.

Top module: `tct_trio`

## Requirements
- R1: A count write (wr_lim=0) loads wr_data[62:0] into the selected counter and wr_data[63] into its NPT flag. The new value is readable in the next cycle, and the counter does not advance in the cycle of the write.
- R2: A counter advances by one on every clock edge where its tick_en bit is high and no count write targets it. Otherwise it holds. It wraps from 2^63-1 to 0.
- R3: A count read returns the counter in bits 62:0 and the NPT flag in bit 63.
- R4: A limit write (wr_lim=1) stores wr_data[62:0] as the compare value and wr_data[63] as the disable flag. A limit read returns the same layout.
- R5: A compare value of zero never produces a pulse, even when the counter wraps through zero.
- R6: While the disable flag is 1, no pulse is produced, even when the counter equals the compare value.
- R7: An armed channel pulses when a tick makes its counter equal the compare value. The pulse is high for exactly one cycle, in the first cycle in which a count read shows the compare value.
- R8: A compare value that is not greater than the counter as it stands after the write edge fires on the next tick of that channel, rather than being missed.
- R9: After a pulse the channel is disarmed. It does not pulse again until a new limit write, even if the counter passes the compare value again.
- R10: After reset every counter is 0 with NPT=1, and every limit is 0 with disable=1. softint_set and wake are low.
- R11: Channel 0 sets softint_set bit 0 and channels 1 and 2 set softint_set bit 16. All other bits stay 0. wake is high exactly when any bit of softint_set is high.
- R12: A write reaches only the channel named by wr_ch. wr_ch=3 changes nothing, and a read with rd_ch=3 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 3 | Per-channel prescaler enable; bit i advances channel i |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 2 | Write channel: 0 tick, 1 system tick, 2 hyper system tick |
| wr_lim | input | 1 | Write target: 0 count, 1 limit |
| wr_data | input | 64 | Write data; bit 63 is NPT or disable |
| rd_ch | input | 2 | Read channel select |
| rd_lim | input | 1 | Read target: 0 count, 1 limit |
| rd_data | output | 64 | Combinational read data |
| softint_set | output | 17 | One-cycle set pulses for the soft-interrupt register |
| wake | output | 1 | One-cycle processor wake pulse |

## Verification
The bench targets four corner cases:
- A limit written at or below the count must fire on the very next tick. A design that compares only for equality would stay silent forever.
- A limit of zero with the counter wrapping through zero must stay silent. A design that arms on any value would pulse at the wrap.
- After a match, the count is rewritten back below the compare value. A design that forgets to disarm would pulse a second time.
- Simultaneous matches on the two system-tick channels, and on the tick plus a system-tick channel, check that the shared bit merges the events and the separate bits stay apart. A wrong bit map would show up as a stray bit or a lost event.

// File: rtl/tct_pkg.sv
package tct_pkg;
  localparam int CNT_W  = 63;
  localparam int REG_W  = CNT_W + 1;
  localparam int NUM_CH = 3;
  localparam int CH_W   = $clog2(NUM_CH + 1);
  localparam int SOFT_W = 17;
  localparam int TM_BIT = 0;
  localparam int SM_BIT = 16;

  typedef enum logic [CH_W-1:0] {
    CH_TICK   = 2'd0,
    CH_STICK  = 2'd1,
    CH_HSTICK = 2'd2
  } ch_role_e;

  // soft-interrupt bit that a channel sets on a match
  function automatic int soft_bit(input int ch);
    return (ch == int'(CH_TICK)) ? TM_BIT : SM_BIT;
  endfunction

  // mask of every bit any channel may drive
  function automatic logic [SOFT_W-1:0] soft_mask();
    logic [SOFT_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_CH; i++) m[soft_bit(i)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/tct_counter.sv
module tct_counter #(
  parameter int W = tct_pkg::CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         ld_en,
  input  logic [W:0]   ld_data,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_next_o,
  output logic         npt_o,
  output logic         step_o
);
  logic [W-1:0] cnt_q;
  logic         npt_q;

  assign step_o = tick_en && !ld_en;

  always_comb begin
    if (ld_en)       cnt_next_o = ld_data[W-1:0];
    else if (step_o) cnt_next_o = cnt_q + W'(1);
    else             cnt_next_o = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      npt_q <= 1'b1;
    end else begin
      cnt_q <= cnt_next_o;
      if (ld_en) npt_q <= ld_data[W];
    end
  end

  assign cnt_o = cnt_q;
  assign npt_o = npt_q;

  assert_count_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !ld_en) |=> (cnt_q == $past(cnt_q) + W'(1)));
  assert_count_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !ld_en) |=> $stable(cnt_q));
  assert_npt_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> $stable(npt_q));
endmodule

// File: rtl/tct_compare.sv
module tct_compare #(
  parameter int W = tct_pkg::CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  input  logic [W-1:0] cnt_next_i,
  input  logic         ld_en,
  input  logic [W:0]   ld_data,
  output logic [W-1:0] lim_o,
  output logic         dis_o,
  output logic         fire_o
);
  logic [W-1:0] lim_q;
  logic         dis_q;
  logic         armed_q;
  logic         late_q;
  logic         fire_q;
  logic         hit;

  assign hit = armed_q && step_i && (late_q || (cnt_next_i == lim_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q   <= '0;
      dis_q   <= 1'b1;
      armed_q <= 1'b0;
      late_q  <= 1'b0;
      fire_q  <= 1'b0;
    end else begin
      fire_q <= hit;
      if (ld_en) begin
        lim_q   <= ld_data[W-1:0];
        dis_q   <= ld_data[W];
        armed_q <= (|ld_data[W-1:0]) && !ld_data[W];
        late_q  <= (ld_data[W-1:0] <= cnt_next_i);
      end else if (hit) begin
        armed_q <= 1'b0;
        late_q  <= 1'b0;
      end
    end
  end

  assign lim_o  = lim_q;
  assign dis_o  = dis_q;
  assign fire_o = fire_q;

  assert_zero_limit_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_q == '0) |=> !fire_q);
  assert_disabled_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dis_q |=> !fire_q);
  assert_late_fires_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && late_q && step_i) |=> fire_q);
  assert_one_shot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_q && !$past(ld_en)) |-> !armed_q);
  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_q && !$past(ld_en)) |=> !fire_q);
endmodule

// File: rtl/tct_channel.sv
module tct_channel #(
  parameter int W = tct_pkg::CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         wr_cnt,
  input  logic         wr_lim,
  input  logic [W:0]   wr_data,
  input  logic         rd_lim,
  output logic [W:0]   rd_data,
  output logic         fire_o
);
  logic [W-1:0] cnt, cnt_next, lim;
  logic         npt, dis, step;

  tct_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .ld_en(wr_cnt), .ld_data(wr_data),
    .cnt_o(cnt), .cnt_next_o(cnt_next), .npt_o(npt), .step_o(step)
  );

  tct_compare #(.W(W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .step_i(step), .cnt_next_i(cnt_next),
    .ld_en(wr_lim), .ld_data(wr_data),
    .lim_o(lim), .dis_o(dis), .fire_o(fire_o)
  );

  assign rd_data = rd_lim ? {dis, lim} : {npt, cnt};
endmodule

// File: rtl/tct_trio.sv
module tct_trio
  import tct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] tick_en,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic              wr_lim,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [CH_W-1:0]   rd_ch,
  input  logic              rd_lim,
  output logic [REG_W-1:0]  rd_data,
  output logic [SOFT_W-1:0] softint_set,
  output logic              wake
);
  logic [NUM_CH-1:0] fire;
  logic [REG_W-1:0]  ch_rd [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic sel;
    assign sel = wr_en && (wr_ch == CH_W'(g));
    tct_channel #(.W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en[g]),
      .wr_cnt(sel && !wr_lim), .wr_lim(sel && wr_lim), .wr_data(wr_data),
      .rd_lim(rd_lim), .rd_data(ch_rd[g]), .fire_o(fire[g])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (rd_ch == CH_W'(i)) rd_data = ch_rd[i];
  end

  always_comb begin
    softint_set = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (fire[i]) softint_set[soft_bit(i)] = 1'b1;
  end

  assign wake = |fire;

  assert_unused_bits_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(softint_set & ~soft_mask()) == 0);
  assert_wake_tracks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wake == (softint_set != '0));
endmodule

// File: tb/tct_trio_tb_top.sv
module tct_trio_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  tick_en = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_ch = '0;
  logic        wr_lim = 1'b0;
  logic [63:0] wr_data = '0;
  logic [1:0]  rd_ch = '0;
  logic        rd_lim = 1'b0;
  logic [63:0] rd_data;
  logic [16:0] softint_set;
  logic        wake;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tct_trio dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_ch(wr_ch),
    .wr_lim(wr_lim), .wr_data(wr_data), .rd_ch(rd_ch), .rd_lim(rd_lim),
    .rd_data(rd_data), .softint_set(softint_set), .wake(wake)
  );

  // behavioural reference state
  logic [62:0] m_cnt [3];
  logic        m_npt [3];
  logic [62:0] m_lim [3];
  logic        m_dis [3];
  logic        m_arm [3];
  logic        m_late[3];
  logic [16:0] m_soft;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 3; c++) begin
      m_cnt[c] = '0; m_npt[c] = 1'b1; m_lim[c] = '0;
      m_dis[c] = 1'b1; m_arm[c] = 1'b0; m_late[c] = 1'b0;
    end
    m_soft = '0;
  endtask

  task automatic model_step();
    m_soft = '0;
    for (int c = 0; c < 3; c++) begin
      bit wc, wl, t, f;
      logic [62:0] nc;
      wc = wr_en && wr_ch == 2'(c) && !wr_lim;
      wl = wr_en && wr_ch == 2'(c) && wr_lim;
      t  = tick_en[c] && !wc;
      nc = wc ? wr_data[62:0] : (t ? m_cnt[c] + 63'd1 : m_cnt[c]);
      f  = m_arm[c] && t && (m_late[c] || nc == m_lim[c]);
      if (f) m_soft[(c == 0) ? 0 : 16] = 1'b1;
      if (wl) begin
        m_lim[c]  = wr_data[62:0];
        m_dis[c]  = wr_data[63];
        m_arm[c]  = (wr_data[62:0] != 0) && !wr_data[63];
        m_late[c] = wr_data[62:0] <= nc;
      end else if (f) begin
        m_arm[c] = 1'b0; m_late[c] = 1'b0;
      end
      if (wc) m_npt[c] = wr_data[63];
      m_cnt[c] = nc;
    end
  endtask

  function automatic logic [63:0] model_read();
    if (rd_ch == 2'd3) return '0;
    return rd_lim ? {m_dis[rd_ch], m_lim[rd_ch]} : {m_npt[rd_ch], m_cnt[rd_ch]};
  endfunction

  // one clock: model update at the edge, comparison at the falling edge
  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R11 softint vs model", 64'(softint_set), 64'(m_soft));
    chk("R11 wake vs model", 64'(wake), 64'(m_soft != 0));
    chk("R3 read vs model", rd_data, model_read());
  endtask

  task automatic wr(input int ch, input bit lim, input logic [63:0] d);
    wr_en = 1'b1; wr_ch = 2'(ch); wr_lim = lim; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic rd(input int ch, input bit lim, input string tag, input logic [63:0] exp);
    rd_ch = 2'(ch); rd_lim = lim; #1;
    chk(tag, rd_data, exp);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rd(0, 0, "R10 reset count", 64'h8000_0000_0000_0000);
    rd(2, 1, "R10 reset limit", 64'h8000_0000_0000_0000);
    chk("R10 reset softint", 64'(softint_set), 64'd0);
    rst_n = 1'b1;
    idle(2);

    // R1 / R3 count write and read
    wr(0, 0, 64'h0000_0000_0000_0100);
    rd(0, 0, "R1 count load", 64'h0000_0000_0000_0100);
    wr(0, 0, 64'h8000_0000_0000_0005);
    rd(0, 0, "R3 count read with NPT", 64'h8000_0000_0000_0005);

    // R2 increment and wrap
    tick_en = 3'b001; idle(4); tick_en = '0;
    rd(0, 0, "R2 four ticks", 64'h8000_0000_0000_0009);
    wr(0, 0, 64'h7FFF_FFFF_FFFF_FFFF);
    tick_en = 3'b001; idle(1); tick_en = '0;
    rd(0, 0, "R2 wrap to zero", 64'h0);

    // R4 limit layout
    wr(1, 1, 64'h8000_0000_0000_1234);
    rd(1, 1, "R4 limit read", 64'h8000_0000_0000_1234);

    // R7 match
    wr(0, 0, 64'd10);
    wr(0, 1, 64'd14);
    rd_ch = 0; rd_lim = 0;
    tick_en = 3'b001; idle(3);
    chk("R7 no early pulse", 64'(softint_set), 64'd0);
    idle(1);
    chk("R7 pulse on match", 64'(softint_set), 64'h1);
    rd(0, 0, "R7 count shows limit", 64'd14);
    idle(1);
    chk("R7 pulse one cycle", 64'(softint_set), 64'd0);

    // R9 one shot
    tick_en = '0; wr(0, 0, 64'd10);
    tick_en = 3'b001; idle(4);
    chk("R9 no second pulse", 64'(softint_set), 64'd0);
    tick_en = '0;

    // R5 zero limit through wrap
    wr(0, 1, 64'd0);
    wr(0, 0, 64'h7FFF_FFFF_FFFF_FFFE);
    tick_en = 3'b001; idle(2);
    chk("R5 zero limit at wrap", 64'(softint_set), 64'd0);
    idle(2); tick_en = '0;

    // R6 disabled
    wr(0, 0, 64'd18);
    wr(0, 1, 64'h8000_0000_0000_0014);
    tick_en = 3'b001; idle(2);
    chk("R6 disabled no pulse", 64'(softint_set), 64'd0);
    idle(2); tick_en = '0;

    // R8 past limit fires on next tick
    wr(2, 0, 64'd100);
    wr(2, 1, 64'd50);
    idle(3);
    chk("R8 waits for tick", 64'(softint_set), 64'd0);
    tick_en = 3'b100; idle(1); tick_en = '0;
    chk("R8 late fire", 64'(softint_set), 64'h1_0000);
    wr(2, 1, 64'd101);
    tick_en = 3'b100; idle(1); tick_en = '0;
    chk("R8 equal to count", 64'(softint_set), 64'h1_0000);

    // R11 merged and separate bits
    wr(1, 0, 64'd0); wr(2, 0, 64'd0);
    wr(1, 1, 64'd3); wr(2, 1, 64'd3);
    tick_en = 3'b110; idle(3); tick_en = '0;
    chk("R11 shared system bit", 64'(softint_set), 64'h1_0000);
    chk("R11 wake", 64'(wake), 64'd1);
    wr(0, 0, 64'd0); wr(1, 0, 64'd0);
    wr(0, 1, 64'd2); wr(1, 1, 64'd2);
    tick_en = 3'b011; idle(2); tick_en = '0;
    chk("R11 both bits", 64'(softint_set), 64'h1_0001);

    // R12 isolation
    wr(0, 0, 64'd77);
    wr(3, 0, 64'd5);
    wr(3, 1, 64'd5);
    rd(0, 0, "R12 channel 3 write ignored", 64'd77);
    rd(3, 0, "R12 channel 3 reads zero", 64'd0);
    wr(1, 0, 64'd9);
    rd(0, 0, "R12 other channel untouched", 64'd77);

    // mixed traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int c;
      c = $urandom_range(0, 2);
      tick_en = 3'($urandom);
      rd_ch = 2'($urandom); rd_lim = 1'($urandom);
      case ($urandom_range(0, 9))
        0: wr(c, 0, {1'($urandom), 63'($urandom_range(0, 40))});
        1: wr(c, 1, {($urandom_range(0, 7) == 0), 63'(m_cnt[c] + 63'($urandom_range(0, 6)) - 63'd2)});
        2: wr(c, 1, 64'd0);
        default: cyc();
      endcase
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule